// File: doc/BRIEF.md
# Quad DAC Serial Command Decoder

This block sits in front of a four-channel digital-to-analog converter. It takes 24-bit command words from a serial link (clock, active-low frame select, data in, data out), decodes a read/write flag, a register class and a channel field, and keeps four 16-bit registers per channel: output code, offset, coarse gain and fine gain. A channel field value of 100 sends a write to all four channels at once. The block presents the four output codes in parallel, so the converter core can use them directly.

The block can return any register over the same link. A read command selects the value, and the next frame shifts that value out. The register class field also reaches a small function register. This register holds the input-coding flag, and a write to it with the broadcast channel field starts a software clear. A falling edge on the clear pin has the same effect as the software clear. A clear sets every output code to 0x0000. In twos complement coding that code means zero volts. In offset binary coding it means the most negative level.

Top module: `qdac_cmd_decoder`

## Requirements
- R1: After reset every output code is 0x8000, the offset and gain registers read 0x0000, and the coding flag reads 0 (offset binary).
- R2: A write frame (bit 23 = 0, bit 22 = 0, class bits 21:19 = 010) with channel bits 18:16 = 000, 001, 010 or 011 loads bits 15:0 into the output code of channel A, B, C or D. Channel A occupies dac_code[15:0] and channel D occupies dac_code[63:48].
- R3: A write with channel field 100 loads the same value into all four channels of the addressed class.
- R4: Class 011 (coarse gain), class 100 (fine gain) and class 101 (offset) store their data per channel, can be read back, and leave the output codes unchanged.
- R5: A read frame (bit 23 = 1) selects the addressed register. The next frame shifts out, MSB first on spi_miso, the old bits 23:16 followed by the 16-bit value.
- R6: A read with channel field 100 returns the register of channel A.
- R7: A frame is ignored and changes no register and no pending readback if it uses class 001, 110 or 111, channel 101 to 111, or has bit 22 set.
- R8: A frame takes effect only when spi_cs_n rises after exactly 24 rising edges of spi_sck. Frames of 23 or 25 bits change nothing.
- R9: A falling edge on clr_n sets all four output codes to 0x0000. Offset and gain registers keep their values.
- R10: After a clear, each output code keeps 0x0000 until a data write reaches that channel.
- R11: If clr_n is low when reset is released, all output codes become 0x0000.
- R12: A function-class write with channel field 100 (frame 0x04xxxx) has the same effect as a clear.
- R13: A function-class write with channel field 001 stores data bit 0 as the coding flag (1 = twos complement). A read of that address returns the flag in bit 0. A clear gives code 0x0000 in both codings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, already synchronous to clk |
| spi_cs_n | input | 1 | Active-low frame select, already synchronous to clk |
| spi_mosi | input | 1 | Serial command data, sampled on spi_sck rising |
| spi_miso | output | 1 | Readback data, advances on spi_sck falling, 0 outside a frame |
| clr_n | input | 1 | Active-low clear, acts on its falling edge |
| dac_code | output | 64 | Four 16-bit output codes, channel A in the low bits |

## Verification
The block treats the serial pins as signals that a synchronizer outside it has already brought into the clk domain. Each level of spi_sck and spi_cs_n must last at least two clk cycles, and spi_sck must not change on the cycle in which spi_cs_n changes. The assertions rely on these rules. For example, they assume that no write lands in the same cycle as a clear edge. The stimulus keeps within these rules: every serial level lasts two clk cycles, and both spi_sck and spi_mosi settle before spi_cs_n moves. The bench also keeps clr_n edges well away from frame ends. It sweeps every class and channel code, so the reserved codes run through the same checks as the valid ones.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  localparam int FRAME_W = 24;
  localparam int DATA_W  = 16;
  localparam int NCH     = 4;
  localparam int CODE_W  = NCH * DATA_W;

  // register class field values
  localparam logic [2:0] CLS_FUNC  = 3'b000;
  localparam logic [2:0] CLS_DATA  = 3'b010;
  localparam logic [2:0] CLS_CGAIN = 3'b011;
  localparam logic [2:0] CLS_FGAIN = 3'b100;
  localparam logic [2:0] CLS_OFFS  = 3'b101;

  // channel field values
  localparam logic [2:0] CH_ALL    = 3'b100;
  localparam logic [2:0] FN_CTRL   = 3'b001;
  localparam logic [2:0] FN_SWCLR  = 3'b100;

  localparam logic [DATA_W-1:0] CLEAR_CODE = '0;
  localparam logic [DATA_W-1:0] RESET_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  typedef struct packed {
    logic              rd;
    logic              zero;
    logic [2:0]        cls;
    logic [2:0]        chan;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef logic [NCH-1:0][DATA_W-1:0] chan_arr_t;

endpackage

// File: rtl/qdac_serial_if.sv
module qdac_serial_if #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               miso,
  input  logic [FRAME_W-1:0] tx_word,
  output logic               frm_vld,
  output logic [FRAME_W-1:0] frm_word
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic               sck_q, cs_q;
  logic [FRAME_W-1:0] rx_q, rx_d, tx_q, tx_d, word_q, word_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               vld_q, vld_d;
  logic               sck_rise, sck_fall, cs_fall, cs_rise, in_frame;

  always_comb begin
    sck_rise = sck & ~sck_q;
    sck_fall = ~sck & sck_q;
    cs_fall  = ~cs_n & cs_q;
    cs_rise  = cs_n & ~cs_q;
    in_frame = ~cs_n & ~cs_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    cnt_d    = cnt_q;
    word_d   = word_q;
    vld_d    = 1'b0;
    if (cs_fall) begin
      cnt_d = '0;
      tx_d  = tx_word;
    end else if (in_frame) begin
      if (sck_rise) begin
        rx_d = {rx_q[FRAME_W-2:0], mosi};
        if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
      end
      if (sck_fall && cnt_q != '0) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    end
    if (cs_rise && cnt_q == CNT_FULL) begin
      vld_d  = 1'b1;
      word_d = rx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      sck_q  <= sck;
      cs_q   <= cs_n;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

  assign miso     = tx_q[FRAME_W-1] & ~cs_q;
  assign frm_vld  = vld_q;
  assign frm_word = word_q;

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
  import qdac_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frm_vld,
  input  cmd_t      frm_cmd,
  input  logic      clr_n,
  output chan_arr_t data_o,
  output chan_arr_t offs_o,
  output chan_arr_t cgain_o,
  output chan_arr_t fgain_o,
  output logic      coding_o
);

  chan_arr_t data_q, data_d, offs_q, offs_d, cg_q, cg_d, fg_q, fg_d;
  logic      coding_q, coding_d;
  logic      clr_q;
  logic      clr_fall, wr_ok, sw_clr, clear_all;

  always_comb begin
    clr_fall  = clr_q & ~clr_n;
    wr_ok     = frm_vld & ~frm_cmd.rd & ~frm_cmd.zero;
    sw_clr    = wr_ok && frm_cmd.cls == CLS_FUNC && frm_cmd.chan == FN_SWCLR;
    clear_all = clr_fall | sw_clr;
    coding_d  = coding_q;
    if (wr_ok && frm_cmd.cls == CLS_FUNC && frm_cmd.chan == FN_CTRL)
      coding_d = frm_cmd.data[0];
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic hit;
    always_comb begin
      hit       = wr_ok && (frm_cmd.chan == 3'(k) || frm_cmd.chan == CH_ALL);
      data_d[k] = data_q[k];
      offs_d[k] = offs_q[k];
      cg_d[k]   = cg_q[k];
      fg_d[k]   = fg_q[k];
      if (hit) begin
        case (frm_cmd.cls)
          CLS_DATA:  data_d[k] = frm_cmd.data;
          CLS_CGAIN: cg_d[k]   = frm_cmd.data;
          CLS_FGAIN: fg_d[k]   = frm_cmd.data;
          CLS_OFFS:  offs_d[k] = frm_cmd.data;
          default:   ;
        endcase
      end
      if (clear_all) data_d[k] = CLEAR_CODE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= {NCH{RESET_CODE}};
      offs_q   <= '0;
      cg_q     <= '0;
      fg_q     <= '0;
      coding_q <= 1'b0;
      clr_q    <= 1'b1;
    end else begin
      data_q   <= data_d;
      offs_q   <= offs_d;
      cg_q     <= cg_d;
      fg_q     <= fg_d;
      coding_q <= coding_d;
      clr_q    <= clr_n;
    end
  end

  assign data_o   = data_q;
  assign offs_o   = offs_q;
  assign cgain_o  = cg_q;
  assign fgain_o  = fg_q;
  assign coding_o = coding_q;

endmodule

// File: rtl/qdac_readback.sv
module qdac_readback
  import qdac_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_vld,
  input  cmd_t               frm_cmd,
  input  chan_arr_t          data_i,
  input  chan_arr_t          offs_i,
  input  chan_arr_t          cgain_i,
  input  chan_arr_t          fgain_i,
  input  logic               coding_i,
  output logic [FRAME_W-1:0] tx_word
);

  localparam int SEL_W = $clog2(NCH);

  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [SEL_W-1:0]   sel;
  logic [DATA_W-1:0]  val;
  logic               ch_ok, cls_ok, rd_ok;

  always_comb begin
    sel    = (frm_cmd.chan == CH_ALL) ? '0 : frm_cmd.chan[SEL_W-1:0];
    ch_ok  = frm_cmd.chan <= CH_ALL;
    cls_ok = 1'b1;
    case (frm_cmd.cls)
      CLS_FUNC:  val = (frm_cmd.chan == FN_CTRL) ? {{(DATA_W-1){1'b0}}, coding_i} : '0;
      CLS_DATA:  val = data_i[sel];
      CLS_CGAIN: val = cgain_i[sel];
      CLS_FGAIN: val = fgain_i[sel];
      CLS_OFFS:  val = offs_i[sel];
      default: begin
        val    = '0;
        cls_ok = 1'b0;
      end
    endcase
    rd_ok = frm_vld & frm_cmd.rd & ~frm_cmd.zero & ch_ok & cls_ok;
    tx_d  = rd_ok ? {frm_cmd.rd, frm_cmd.zero, frm_cmd.cls, frm_cmd.chan, val} : tx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign tx_word = tx_q;

endmodule

// File: rtl/qdac_cmd_decoder.sv
module qdac_cmd_decoder
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              clr_n,
  output logic [CODE_W-1:0] dac_code
);

  logic               frm_vld;
  logic [FRAME_W-1:0] frm_word;
  logic [FRAME_W-1:0] tx_word;
  cmd_t               frm_cmd;
  chan_arr_t          data_a, offs_a, cg_a, fg_a;
  logic               coding;

  assign frm_cmd = cmd_t'(frm_word);

  qdac_serial_if #(.FRAME_W(FRAME_W)) u_serial (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .miso     (spi_miso),
    .tx_word  (tx_word),
    .frm_vld  (frm_vld),
    .frm_word (frm_word)
  );

  qdac_regbank u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_vld  (frm_vld),
    .frm_cmd  (frm_cmd),
    .clr_n    (clr_n),
    .data_o   (data_a),
    .offs_o   (offs_a),
    .cgain_o  (cg_a),
    .fgain_o  (fg_a),
    .coding_o (coding)
  );

  qdac_readback u_rdbk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_vld  (frm_vld),
    .frm_cmd  (frm_cmd),
    .data_i   (data_a),
    .offs_i   (offs_a),
    .cgain_i  (cg_a),
    .fgain_i  (fg_a),
    .coding_i (coding),
    .tx_word  (tx_word)
  );

  assign dac_code = data_a;

endmodule

// File: rtl/qdac_cmd_decoder_chk.sv
module qdac_cmd_decoder_chk
  import qdac_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clr_n,
  input logic [CODE_W-1:0]  dac_code,
  input logic               frm_vld,
  input logic [FRAME_W-1:0] frm_word,
  input logic               coding
);

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R2 R3
    data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && clr_n && frm_word[23:22] == 2'b00 && frm_word[21:19] == CLS_DATA &&
       (frm_word[18:16] == 3'(k) || frm_word[18:16] == CH_ALL))
      |=> dac_code[k*DATA_W +: DATA_W] == $past(frm_word[DATA_W-1:0]));
  end

  // R9
  hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_n) |=> dac_code == '0);

  // R7
  rsvd_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && clr_n && (frm_word[21:19] == 3'b001 || frm_word[21:19] == 3'b110 ||
                          frm_word[21:19] == 3'b111))
    |=> $stable(dac_code) && $stable(coding));

  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_vld && clr_n) |=> $stable(dac_code));

  // R13
  coding_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> $stable(coding));

endmodule

bind qdac_cmd_decoder qdac_cmd_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .dac_code (dac_code),
  .frm_vld  (frm_vld),
  .frm_word (frm_word),
  .coding   (coding)
);

// File: tb/qdac_cmd_decoder_tb.sv
module qdac_cmd_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n, spi_sck, spi_cs_n, spi_mosi, clr_n;
  logic        spi_miso;
  logic [63:0] dac_code;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [15:0] mdl [4][4];   // class idx: 0 data,1 cgain,2 fgain,3 offs
  logic        mcoding;
  logic [23:0] last_tx;

  qdac_cmd_decoder u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso),
    .clr_n    (clr_n),
    .dac_code (dac_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog expired act=%0d exp<%0d", cycles, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int cidx(input logic [2:0] cls);
    case (cls)
      3'b010: return 0;
      3'b011: return 1;
      3'b100: return 2;
      3'b101: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 4; k++) mdl[c][k] = (c == 0) ? 16'h8000 : 16'h0000;
    mcoding = 1'b0;
    last_tx = '0;
  endtask

  task automatic model_clear();
    for (int k = 0; k < 4; k++) mdl[0][k] = 16'h0000;
  endtask

  // model of a well-formed 24-bit write
  task automatic model_write(input logic [23:0] w);
    int c;
    if (w[23] || w[22]) return;
    c = cidx(w[21:19]);
    if (c >= 0) begin
      if (w[18:16] == 3'b100) for (int k = 0; k < 4; k++) mdl[c][k] = w[15:0];
      else if (w[18:16] < 3'b100) mdl[c][w[17:16]] = w[15:0];
    end else if (w[21:19] == 3'b000) begin
      if (w[18:16] == 3'b001) mcoding = w[0];
      if (w[18:16] == 3'b100) model_clear();
    end
  endtask

  function automatic logic [15:0] model_read(input logic [2:0] cls, input logic [2:0] ch);
    int c;
    int k;
    c = cidx(cls);
    k = (ch == 3'b100) ? 0 : int'(ch[1:0]);
    if (c >= 0) return mdl[c][k];
    return (ch == 3'b001) ? {15'b0, mcoding} : 16'h0000;
  endfunction

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got);
    got = '0;
    spi_cs_n = 1'b0;
    cyc(2);
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = (i < 24) ? w[23-i] : 1'b0;
      cyc(2);
      if (i < 24) got[23-i] = spi_miso;
      spi_sck = 1'b1;
      cyc(2);
      spi_sck = 1'b0;
    end
    cyc(2);
    spi_cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic wr(input logic [23:0] w);
    logic [23:0] g;
    xfer(w, 24, g);
  endtask

  task automatic check_dac(input string req);
    for (int k = 0; k < 4; k++) check(req, {16'h0, dac_code[k*16 +: 16]}, {16'h0, mdl[0][k]});
  endtask

  // read with a reserved-class write as the carrier frame
  task automatic rd_check(input logic [2:0] cls, input logic [2:0] ch, input string req);
    logic [23:0] g;
    logic [23:0] exp;
    wr({1'b1, 1'b0, cls, ch, 16'h0000});
    xfer({2'b00, 3'b001, 3'b000, 16'h0000}, 24, g);
    if (cidx(cls) >= 0 || cls == 3'b000) begin
      if (ch <= 3'b100) last_tx = {1'b1, 1'b0, cls, ch, model_read(cls, ch)};
    end
    exp = last_tx;
    check(req, {8'h0, g}, {8'h0, exp});
  endtask

  task automatic do_reset(input logic clr_level);
    rst_n = 1'b0;
    clr_n = clr_level;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    model_reset();
  endtask

  initial begin
    logic [23:0] g;
    logic [15:0] v;
    spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    do_reset(1'b1);

    // R1: reset state
    check_dac("R1 reset code");
    rd_check(3'b000, 3'b001, "R1 coding reset");
    rd_check(3'b101, 3'b010, "R1 offset reset");
    rd_check(3'b011, 3'b011, "R1 coarse reset");

    // R2 R3 R4 R7 R12 R13: sweep of every class and channel code
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 8; k++) begin
        v = 16'h1000 * 16'(c + 1) + 16'h0111 * 16'(k) + 16'h0005;
        wr({2'b00, 3'(c), 3'(k), v});
        model_write({2'b00, 3'(c), 3'(k), v});
        check_dac("R2 R3 R4 R7 sweep write");
      end
    end

    // R5 R6 R7: readback sweep
    for (int c = 0; c < 8; c++)
      for (int k = 0; k < 8; k++)
        rd_check(3'(c), 3'(k), "R5 R6 R7 readback");

    // refill distinct values
    for (int k = 0; k < 4; k++) begin
      wr({2'b00, 3'b010, 3'(k), 16'hC000 + 16'(k)});
      model_write({2'b00, 3'b010, 3'(k), 16'hC000 + 16'(k)});
    end
    check_dac("R2 refill");

    // R7: bit 22 set
    wr({2'b01, 3'b010, 3'b000, 16'h1234});
    check_dac("R7 bit22 ignored");

    // R8: 23- and 25-bit frames
    xfer({2'b00, 3'b010, 3'b001, 16'h5555}, 23, g);
    check_dac("R8 short frame");
    xfer({2'b00, 3'b010, 3'b010, 16'h6666}, 25, g);
    check_dac("R8 long frame");

    // R9 R10: hardware clear in offset binary
    wr({2'b00, 3'b101, 3'b011, 16'h0ABC});
    model_write({2'b00, 3'b101, 3'b011, 16'h0ABC});
    clr_n = 1'b0;
    cyc(3);
    model_clear();
    check_dac("R9 hw clear");
    clr_n = 1'b1;
    cyc(6);
    check_dac("R10 hold after clear");
    rd_check(3'b101, 3'b011, "R9 offset kept");
    wr({2'b00, 3'b010, 3'b001, 16'h7777});
    model_write({2'b00, 3'b010, 3'b001, 16'h7777});
    check_dac("R10 single channel restored");

    // R13: twos complement, then clear
    wr({2'b00, 3'b000, 3'b001, 16'h0001});
    model_write({2'b00, 3'b000, 3'b001, 16'h0001});
    rd_check(3'b000, 3'b001, "R13 coding set");
    wr({2'b00, 3'b010, 3'b100, 16'h4321});
    model_write({2'b00, 3'b010, 3'b100, 16'h4321});
    clr_n = 1'b0;
    cyc(3);
    model_clear();
    check_dac("R13 clear code twos");
    clr_n = 1'b1;
    cyc(3);

    // R12: software clear
    wr({2'b00, 3'b010, 3'b100, 16'h2468});
    model_write({2'b00, 3'b010, 3'b100, 16'h2468});
    check_dac("R3 broadcast");
    wr(24'h04ABCD);
    model_write(24'h04ABCD);
    check_dac("R12 sw clear");
    rd_check(3'b000, 3'b001, "R12 coding kept");

    // R11: clear low at reset release
    do_reset(1'b0);
    model_clear();
    check_dac("R11 clear at reset");
    clr_n = 1'b1;
    cyc(3);
    check_dac("R11 hold");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule